// File: doc/BRIEF.md
# Floating-point status field move unit

This unit holds two 32-bit registers side by side: a floating-point status and control word and a condition word. Both are split into eight 4-bit fields. Field 0 is the most significant nibble and field k occupies bits [31-4k : 28-4k]. A move operation names a source field of the status word and a destination field of the condition word. It copies the source nibble into the destination nibble of the condition word.

In the same clock, the move acknowledges the exceptions it has just read. Only the sticky exception flags inside the source field are cleared. Enable bits, result flags, the rounding mode and the reserved bit keep their values. After the clear, the two summary bits of the status word are recomputed from the whole register:

- The invalid-operation summary is recomputed first.
- The enabled-exception summary is recomputed from the new invalid summary and the other flags.

A software read of the rounding mode therefore does not destroy it, and the summaries never report an exception that no longer exists.

A load port initialises both registers at once. An operation and a load share no resources beyond the two registers.

Top module: `fsfm_unit`

## Requirements
- R1: A synchronous active-high reset sets both the status word and the condition word to zero.
- R2: When an operation is accepted, the status nibble selected by `src_fld` is copied into the condition nibble selected by `dst_fld`. Field k is bits [31-4k : 28-4k]. The other seven condition nibbles are unchanged.
- R3: An accepted operation clears only the sticky flags of the source field. The flags per source field are:
  - Field 0: bits 31 and 28.
  - Field 1: bits 27..24.
  - Field 2: bits 23..20.
  - Field 3: bit 19.
  - Field 5: bits 10..8.

  No other bit outside the two summary positions changes.
- R4: Reading field 4, 6 or 7 clears no bit of that field. In particular, the rounding mode in bits 1..0 survives repeated reads of field 7, and each read returns it.
- R5: After every accepted operation, bit 29 (invalid summary) equals the OR of bits 24..19 and 10..8, taken after the clear, even when the field read holds none of these bits.
- R6: After every accepted operation, bit 30 (enabled summary) equals the OR of five pairs, all taken after the clear and after R5:
  - bit 29 with bit 7;
  - bit 28 with bit 6;
  - bit 27 with bit 5;
  - bit 26 with bit 4;
  - bit 25 with bit 3.
- R7: The condition word receives the source nibble as it was before the clear. This includes the old summary bits when field 0 is read.
- R8: With `op_valid` low and `init_en` low, both registers hold their values whatever the operand inputs carry.
- R9: When `init_en` is high, `init_stat` and `init_cond` are written on the next edge, and any operation presented in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept a field move this cycle |
| src_fld | input | 3 | Status field to read and acknowledge |
| dst_fld | input | 3 | Condition field to write |
| init_en | input | 1 | Load both registers, wins over op_valid |
| init_stat | input | 32 | Value loaded into the status word |
| init_cond | input | 32 | Value loaded into the condition word |
| stat_q | output | 32 | Current status word |
| cond_q | output | 32 | Current condition word |

## Verification
The move is tried with an all-ones status word, reading every field into a different destination. This separates fields that clear from fields that do not, and exposes a wrong field offset in either register.

A rounding-mode-only word read twice from field 7 tells a selective clear from a whole-field clear. Words whose only invalid flag lies in field 3, with and without a second flag in field 5, tell a whole-register summary from a field-local one or a stale one. An overflow flag with its enable set, read first through an unrelated field and then through field 0, separates summary recomputation from plain clearing.

A field-0 read with both summaries set checks that the copy takes pre-clear data. Idle cycles with live operands and a load colliding with an operation cover the hold and priority rules.

// File: rtl/fsfm_pkg.sv
package fsfm_pkg;
    localparam int REG_W   = 32;
    localparam int FLD_W   = 4;
    localparam int NUM_FLD = REG_W / FLD_W;
    localparam int SEL_W   = $clog2(NUM_FLD);

    typedef logic [REG_W-1:0] word_t;
    typedef logic [FLD_W-1:0] nib_t;
    typedef logic [SEL_W-1:0] sel_t;

    // bit positions in the status word
    localparam int B_ANY_EXC   = 31;
    localparam int B_EN_SUM    = 30;
    localparam int B_INV_SUM   = 29;
    localparam int B_OVF       = 28;
    localparam int B_UNF       = 27;
    localparam int B_DIVZ      = 26;
    localparam int B_INEX      = 25;
    localparam int B_INV_SNAN  = 24;
    localparam int B_INV_ISI   = 23;
    localparam int B_INV_IDI   = 22;
    localparam int B_INV_ZDZ   = 21;
    localparam int B_INV_IMZ   = 20;
    localparam int B_INV_CMP   = 19;
    localparam int B_INV_SW    = 10;
    localparam int B_INV_SQRT  = 9;
    localparam int B_INV_CONV  = 8;
    localparam int B_EN_INV    = 7;
    localparam int B_EN_OVF    = 6;
    localparam int B_EN_UNF    = 5;
    localparam int B_EN_DIVZ   = 4;
    localparam int B_EN_INEX   = 3;

    localparam word_t ONE = word_t'(1);

    localparam word_t INV_SRC_MASK =
        (ONE << B_INV_SNAN) | (ONE << B_INV_ISI) | (ONE << B_INV_IDI) |
        (ONE << B_INV_ZDZ)  | (ONE << B_INV_IMZ) | (ONE << B_INV_CMP) |
        (ONE << B_INV_SW)   | (ONE << B_INV_SQRT) | (ONE << B_INV_CONV);

    localparam word_t SUM_MASK = (ONE << B_EN_SUM) | (ONE << B_INV_SUM);

    typedef struct packed {
        logic valid;
        sel_t src;
        sel_t dst;
    } move_op_t;

    // sticky flags acknowledged by reading a given field
    function automatic word_t sticky_mask(sel_t f);
        word_t m;
        case (f)
            sel_t'(0): m = (ONE << B_ANY_EXC) | (ONE << B_OVF);
            sel_t'(1): m = (ONE << B_UNF) | (ONE << B_DIVZ) |
                           (ONE << B_INEX) | (ONE << B_INV_SNAN);
            sel_t'(2): m = (ONE << B_INV_ISI) | (ONE << B_INV_IDI) |
                           (ONE << B_INV_ZDZ) | (ONE << B_INV_IMZ);
            sel_t'(3): m = (ONE << B_INV_CMP);
            sel_t'(5): m = (ONE << B_INV_SW) | (ONE << B_INV_SQRT) |
                           (ONE << B_INV_CONV);
            default:   m = '0;
        endcase
        return m;
    endfunction

    function automatic nib_t get_fld(word_t w, sel_t f);
        return w[REG_W-1-FLD_W*int'(f) -: FLD_W];
    endfunction
endpackage

// File: rtl/fsfm_field_pick.sv
module fsfm_field_pick
    import fsfm_pkg::*;
(
    input  word_t src_word,
    input  sel_t  sel,
    output nib_t  nib
);
    nib_t fields [NUM_FLD];

    for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
        assign fields[k] = src_word[REG_W-1-FLD_W*k -: FLD_W];
    end

    assign nib = fields[sel];
endmodule

// File: rtl/fsfm_field_place.sv
module fsfm_field_place
    import fsfm_pkg::*;
(
    input  word_t base,
    input  nib_t  nib,
    input  sel_t  sel,
    output word_t merged
);
    for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
        assign merged[REG_W-1-FLD_W*k -: FLD_W] =
            (sel == sel_t'(k)) ? nib : base[REG_W-1-FLD_W*k -: FLD_W];
    end
endmodule

// File: rtl/fsfm_sticky_clear.sv
module fsfm_sticky_clear
    import fsfm_pkg::*;
(
    input  word_t stat_in,
    input  sel_t  sel,
    output word_t stat_out
);
    word_t cleared;
    logic  inv_sum;
    logic  en_sum;

    always_comb begin
        cleared = stat_in & ~sticky_mask(sel);
        inv_sum = |(cleared & INV_SRC_MASK);
        en_sum  = (inv_sum            & cleared[B_EN_INV])  |
                  (cleared[B_OVF]     & cleared[B_EN_OVF])  |
                  (cleared[B_UNF]     & cleared[B_EN_UNF])  |
                  (cleared[B_DIVZ]    & cleared[B_EN_DIVZ]) |
                  (cleared[B_INEX]    & cleared[B_EN_INEX]);
        stat_out = cleared;
        stat_out[B_INV_SUM] = inv_sum;
        stat_out[B_EN_SUM]  = en_sum;
    end
endmodule

// File: rtl/fsfm_unit.sv
module fsfm_unit
    import fsfm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [SEL_W-1:0] src_fld,
    input  logic [SEL_W-1:0] dst_fld,
    input  logic             init_en,
    input  logic [REG_W-1:0] init_stat,
    input  logic [REG_W-1:0] init_cond,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] cond_q
);
    move_op_t op;
    nib_t     picked;
    word_t    cond_nxt;
    word_t    stat_nxt;

    assign op = '{valid: op_valid, src: src_fld, dst: dst_fld};

    fsfm_field_pick u_pick (
        .src_word (stat_q),
        .sel      (op.src),
        .nib      (picked)
    );

    fsfm_field_place u_place (
        .base   (cond_q),
        .nib    (picked),
        .sel    (op.dst),
        .merged (cond_nxt)
    );

    fsfm_sticky_clear u_clear (
        .stat_in  (stat_q),
        .sel      (op.src),
        .stat_out (stat_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            cond_q <= '0;
        end else if (init_en) begin
            stat_q <= init_stat;
            cond_q <= init_cond;
        end else if (op.valid) begin
            stat_q <= stat_nxt;
            cond_q <= cond_nxt;
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && cond_q == '0)); // R1

    AST_COPY_FIELD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !init_en) |=>
        get_fld(cond_q, $past(dst_fld)) == get_fld($past(stat_q), $past(src_fld))); // R2

    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !init_en) |=>
        ((stat_q & ~$past(stat_q) & ~SUM_MASK) == '0)); // R3

    AST_ROUND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !init_en) |=> (stat_q[1:0] == $past(stat_q[1:0]))); // R4

    AST_INV_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !init_en) |=> (stat_q[B_INV_SUM] == |(stat_q & INV_SRC_MASK))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !init_en) |=> ($stable(stat_q) && $stable(cond_q))); // R8

    AST_INIT_WINS: assert property (@(posedge clk) disable iff (rst)
        init_en |=> (stat_q == $past(init_stat) && cond_q == $past(init_cond))); // R9
endmodule

// File: tb/fsfm_unit_test.sv
module fsfm_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  src_fld;
    logic [2:0]  dst_fld;
    logic        init_en;
    logic [31:0] init_stat;
    logic [31:0] init_cond;
    logic [31:0] stat_q;
    logic [31:0] cond_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsfm_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .src_fld(src_fld),
        .dst_fld(dst_fld), .init_en(init_en), .init_stat(init_stat),
        .init_cond(init_cond), .stat_q(stat_q), .cond_q(cond_q)
    );

    function automatic logic [31:0] model_stat(logic [31:0] s, int f);
        logic vx;
        case (f)
            0: begin s[31] = 1'b0; s[28] = 1'b0; end
            1: s[27:24] = 4'h0;
            2: s[23:20] = 4'h0;
            3: s[19] = 1'b0;
            5: s[10:8] = 3'h0;
            default: ;
        endcase
        vx = s[24] | s[23] | s[22] | s[21] | s[20] | s[19] | s[10] | s[9] | s[8];
        s[29] = vx;
        s[30] = (vx & s[7]) | (s[28] & s[6]) | (s[27] & s[5]) |
                (s[26] & s[4]) | (s[25] & s[3]);
        return s;
    endfunction

    function automatic logic [31:0] model_cond(logic [31:0] c, logic [31:0] s, int f, int d);
        c[31-4*d -: 4] = s[31-4*f -: 4];
        return c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(logic [31:0] s, logic [31:0] c);
        @(negedge clk);
        init_en = 1'b1; init_stat = s; init_cond = c;
        @(negedge clk);
        init_en = 1'b0;
    endtask

    task automatic move(int f, int d);
        @(negedge clk);
        op_valid = 1'b1; src_fld = 3'(f); dst_fld = 3'(d);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 stat", stat_q, 32'h0);
        check("R1 cond", cond_q, 32'h0);
    endtask

    task automatic t_all_fields;
        for (int f = 0; f < 8; f++) begin
            logic [31:0] s0, c0;
            s0 = 32'hFFFF_FFFF; c0 = 32'h1234_5678;
            load(s0, c0);
            move(f, 7 - f);
            check($sformatf("R2 cond field %0d", f), cond_q, model_cond(c0, s0, f, 7 - f));
            check($sformatf("R3 stat field %0d", f), stat_q, model_stat(s0, f));
        end
    endtask

    task automatic t_round_keep;
        load(32'h0000_0002, 32'h0);
        move(7, 7);
        check("R4 first read cond", cond_q, 32'h0000_0002);
        move(7, 7);
        check("R4 second read cond", cond_q, 32'h0000_0002);
        check("R4 stat kept", stat_q, 32'h0000_0002);
        load(32'h0000_F0FF & ~32'h0000_0700, 32'h0);
        move(4, 0);
        check("R4 field4 kept", stat_q, 32'h0000_F0FF & ~32'h0000_0700);
    endtask

    task automatic t_summary;
        logic [31:0] s0;
        // invalid compare flag only, enable-invalid set, both summaries set
        s0 = 32'hE008_0080;
        load(s0, 32'h0);
        move(3, 2);
        check("R5 inv summary drops", stat_q, 32'h8000_0080);
        check("R2 cond field3", cond_q, 32'h0080_0000);
        // a second invalid flag in field 5 keeps the summary
        s0 = 32'hE008_0480;
        load(s0, 32'h0);
        move(3, 1);
        check("R5 inv summary stays", stat_q, 32'hE000_0480);
        // overflow with its enable
        s0 = 32'hD000_0040;
        load(s0, 32'h0);
        move(1, 1);
        check("R6 en summary stays", stat_q, 32'hD000_0040);
        move(0, 0);
        check("R6 en summary drops", stat_q, 32'h0000_0040);
    endtask

    task automatic t_pre_clear;
        load(32'hF000_0040, 32'h0000_0000);
        move(0, 3);
        check("R7 cond old summaries", cond_q, 32'h000F_0000);
        check("R7 stat", stat_q, model_stat(32'hF000_0040, 0));
    endtask

    task automatic t_idle;
        load(32'hFFFF_FFFF, 32'hA5A5_A5A5);
        @(negedge clk);
        src_fld = 3'd0; dst_fld = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check("R8 stat held", stat_q, 32'hFFFF_FFFF);
        check("R8 cond held", cond_q, 32'hA5A5_A5A5);
    endtask

    task automatic t_priority;
        @(negedge clk);
        init_en = 1'b1; init_stat = 32'h0F0F_0F0F; init_cond = 32'h3C3C_3C3C;
        op_valid = 1'b1; src_fld = 3'd1; dst_fld = 3'd0;
        @(negedge clk);
        init_en = 1'b0; op_valid = 1'b0;
        check("R9 stat loaded", stat_q, 32'h0F0F_0F0F);
        check("R9 cond loaded", cond_q, 32'h3C3C_3C3C);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; init_en = 1'b0;
        src_fld = '0; dst_fld = '0; init_stat = '0; init_cond = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_all_fields();
        t_round_keep();
        t_summary();
        t_pre_clear();
        t_idle();
        t_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule